// File: doc/BRIEF.md
# On-Chip SRAM Access Controller

This block sits in front of a 256 KB on-chip SRAM. Two masters share the memory: a processor port and an interconnect port. The interconnect port has separate read and write request channels. Each cycle the controller picks at most one request and checks it against a per-page attribute table. If the attribute allows the access, it is issued on a single-ported synchronous SRAM interface. If not, the memory is left alone and the requester gets an error response instead.

The memory is divided into 64 pages of 4 KB. Each page has two attribute bits, held in a table that a separate configuration write port programs: a secure flag and a read-only flag. Every denied access sets a sticky cause bit, and while any cause bit is set the interrupt output is high. Software clears the cause bits with a clear strobe.

Every grant gets exactly one response, one cycle after the grant, on the port that issued it. For a permitted read, that response carries the SRAM data.

Top module: `ocsram_guard`

## Requirements
- R1: While `cpu_req_i` is high, the processor port is granted in that same cycle, and neither interconnect channel is granted.
- R2: At most one of the three grants is high in any cycle. `sram_req_o` is high only in a cycle with a grant.
- R3: When the processor is idle and both interconnect channels request, the grant goes to the channel that was not the last interconnect channel granted. After reset, the read channel goes first.
- R4: When the processor is idle and only one interconnect channel requests, that channel is granted in the same cycle.
- R5: Address ports carry word addresses, which are byte-address bits [17:2]. A permitted access is issued on the SRAM port in the grant cycle. The cycle after the grant, the granting port shows `*_rsp_valid_o` with its error flag low. For a read, that response carries the SRAM word, so data written earlier reads back. Write responses carry zero data.
- R6: The page index is byte-address bits [17:12], i.e. word-address bits [15:10]. The table has one entry per page. Writing `cfg_we_i` stores `cfg_sec_i` and `cfg_ro_i` for page `cfg_page_i`. After reset, every page is non-secure and writable.
- R7: An access with its non-secure flag set (`*_ns_i`=1) to a page marked secure is not issued to the SRAM. Its response has the error flag high and zero data.
- R8: A write to a page marked read-only is denied whatever its security flag, and the stored word stays unchanged. Reads of a read-only page are allowed.
- R9: `status_o` bit 0 records security denials and bit 1 records read-only denials. Each bit is set from the cycle after the denial and holds until `cfg_clr_i`. A denial in the same cycle as `cfg_clr_i` still sets its bit. `irq_o` is the OR of the two bits. Both are 0 after reset.
- R10: A configuration write takes effect from the next cycle. An access granted in the same cycle as a configuration write to its page is judged by the old attribute.
- R11: An access with the non-secure flag clear, to a secure page that is not read-only, is performed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until granted |
| cpu_we_i | input | 1 | Processor write (1) or read (0) |
| cpu_ns_i | input | 1 | Processor access is non-secure |
| cpu_addr_i | input | 16 | Processor word address |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_gnt_o | output | 1 | Processor request granted |
| cpu_rsp_valid_o | output | 1 | Processor response valid |
| cpu_rsp_err_o | output | 1 | Processor access was denied |
| cpu_rsp_data_o | output | 32 | Processor read data |
| ic_rd_req_i | input | 1 | Interconnect read request |
| ic_rd_ns_i | input | 1 | Interconnect read is non-secure |
| ic_rd_addr_i | input | 16 | Interconnect read word address |
| ic_rd_gnt_o | output | 1 | Interconnect read granted |
| ic_wr_req_i | input | 1 | Interconnect write request |
| ic_wr_ns_i | input | 1 | Interconnect write is non-secure |
| ic_wr_addr_i | input | 16 | Interconnect write word address |
| ic_wr_data_i | input | 32 | Interconnect write data |
| ic_wr_gnt_o | output | 1 | Interconnect write granted |
| ic_rsp_valid_o | output | 1 | Interconnect response valid |
| ic_rsp_wr_o | output | 1 | Interconnect response belongs to a write |
| ic_rsp_err_o | output | 1 | Interconnect access was denied |
| ic_rsp_data_o | output | 32 | Interconnect read data |
| cfg_we_i | input | 1 | Attribute table write strobe |
| cfg_page_i | input | 6 | Page to program |
| cfg_sec_i | input | 1 | Secure flag to store |
| cfg_ro_i | input | 1 | Read-only flag to store |
| cfg_clr_i | input | 1 | Clear the sticky denial status |
| status_o | output | 2 | Sticky denial causes |
| irq_o | output | 1 | Denial interrupt |
| sram_req_o | output | 1 | SRAM access strobe |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 16 | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, one cycle after the strobe |

## Verification
The delicate collision is a configuration write that lands in the same cycle as a granted access to the page being reprogrammed. The bench marks an open page secure while issuing, in that same cycle, a non-secure interconnect read to it. That read must complete without error. An identical read one cycle later must be refused. A second collision, a status clear in the same cycle as a fresh denial, is judged by the status bits in the following cycle. Contention among all three requesters is provoked from reset and judged grant by grant.

// File: rtl/ocsram_guard_pkg.sv
package ocsram_guard_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_RD   = 2'd2,
    SRC_WR   = 2'd3
  } src_e;

  typedef struct packed {
    logic ro;
    logic sec;
  } pattr_t;
endpackage

// File: rtl/ocsram_guard_arb.sv
module ocsram_guard_arb
  import ocsram_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output src_e src_o,
  output logic cpu_gnt_o,
  output logic rd_gnt_o,
  output logic wr_gnt_o
);
  logic pref_wr_q;
  src_e src_d;

  always_comb begin
    src_d = SRC_NONE;
    if (cpu_req_i)                  src_d = SRC_CPU;
    else if (rd_req_i && wr_req_i)  src_d = pref_wr_q ? SRC_WR : SRC_RD;
    else if (rd_req_i)              src_d = SRC_RD;
    else if (wr_req_i)              src_d = SRC_WR;
  end

  // pointer moves on every interconnect grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pref_wr_q <= 1'b0;
    else if (src_d == SRC_RD) pref_wr_q <= 1'b1;
    else if (src_d == SRC_WR) pref_wr_q <= 1'b0;
  end

  assign src_o     = src_d;
  assign cpu_gnt_o = (src_d == SRC_CPU);
  assign rd_gnt_o  = (src_d == SRC_RD);
  assign wr_gnt_o  = (src_d == SRC_WR);

  AST_CPU_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |-> cpu_gnt_o && !rd_gnt_o && !wr_gnt_o); // R1
  AST_ONE_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cpu_gnt_o, rd_gnt_o, wr_gnt_o}) <= 1); // R2
  AST_ALT_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt_o |=> (!(rd_req_i && wr_req_i && !cpu_req_i) || wr_gnt_o)); // R3
  AST_ALT_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gnt_o |=> (!(rd_req_i && wr_req_i && !cpu_req_i) || rd_gnt_o)); // R3
  AST_SINGLE_IC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_req_i && (rd_req_i ^ wr_req_i)) |-> (rd_gnt_o == rd_req_i) && (wr_gnt_o == wr_req_i)); // R4
endmodule

// File: rtl/ocsram_guard_attr.sv
module ocsram_guard_attr
  import ocsram_guard_pkg::*;
#(
  parameter int PAGE_NUM = 64,
  localparam int PAGE_W  = $clog2(PAGE_NUM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  pattr_t            cfg_attr_i,
  input  logic [PAGE_W-1:0] look_page_i,
  output pattr_t            look_attr_o
);
  pattr_t              tbl_q [PAGE_NUM];
  logic [PAGE_NUM-1:0] wsel;

  for (genvar p = 0; p < PAGE_NUM; p++) begin : g_sel
    assign wsel[p] = cfg_we_i && (cfg_page_i == PAGE_W'(p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAGE_NUM; p++) tbl_q[p] <= '0;
    end else begin
      for (int p = 0; p < PAGE_NUM; p++)
        if (wsel[p]) tbl_q[p] <= cfg_attr_i;
    end
  end

  assign look_attr_o = tbl_q[look_page_i];

  AST_CFG_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (look_page_i != $past(cfg_page_i)) || (look_attr_o == $past(cfg_attr_i))); // R10
endmodule

// File: rtl/ocsram_guard_rsp.sv
module ocsram_guard_rsp
  import ocsram_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic              we_i,
  input  logic              sec_deny_i,
  input  logic              wp_deny_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              cpu_rsp_valid_o,
  output logic              cpu_rsp_err_o,
  output logic [DATA_W-1:0] cpu_rsp_data_o,
  output logic              ic_rsp_valid_o,
  output logic              ic_rsp_wr_o,
  output logic              ic_rsp_err_o,
  output logic [DATA_W-1:0] ic_rsp_data_o,
  output logic [1:0]        status_o,
  output logic              irq_o
);
  logic       cpu_v_q, ic_v_q, err_q, wr_q;
  logic [1:0] st_q;
  logic       data_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_v_q <= 1'b0;
      ic_v_q  <= 1'b0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
      st_q    <= '0;
    end else begin
      cpu_v_q <= (src_i == SRC_CPU);
      ic_v_q  <= (src_i == SRC_RD) || (src_i == SRC_WR);
      err_q   <= sec_deny_i || wp_deny_i;
      wr_q    <= we_i;
      // a denial in the clearing cycle still lands
      st_q[0] <= (st_q[0] && !clr_i) || sec_deny_i;
      st_q[1] <= (st_q[1] && !clr_i) || wp_deny_i;
    end
  end

  assign data_ok         = !err_q && !wr_q;
  assign cpu_rsp_valid_o = cpu_v_q;
  assign cpu_rsp_err_o   = cpu_v_q && err_q;
  assign cpu_rsp_data_o  = (cpu_v_q && data_ok) ? sram_rdata_i : '0;
  assign ic_rsp_valid_o  = ic_v_q;
  assign ic_rsp_wr_o     = ic_v_q && wr_q;
  assign ic_rsp_err_o    = ic_v_q && err_q;
  assign ic_rsp_data_o   = (ic_v_q && data_ok) ? sram_rdata_i : '0;
  assign status_o        = st_q;
  assign irq_o           = |st_q;

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != SRC_NONE) |=> (cpu_rsp_valid_o ^ ic_rsp_valid_o)); // R5
  AST_STICKY_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !clr_i) |=> status_o[0]); // R9
  AST_STICKY_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !clr_i) |=> status_o[1]); // R9
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rsp_err_o || ic_rsp_err_o) |-> (cpu_rsp_data_o == '0) && (ic_rsp_data_o == '0)); // R7
endmodule

// File: rtl/ocsram_guard.sv
module ocsram_guard
  import ocsram_guard_pkg::*;
#(
  parameter int  PAGE_NUM   = 64,
  parameter int  PAGE_BYTES = 4096,
  parameter int  DATA_W     = 32,
  localparam int PAGE_W     = $clog2(PAGE_NUM),
  localparam int BYTE_W     = $clog2(DATA_W / 8),
  localparam int OFF_W      = $clog2(PAGE_BYTES) - BYTE_W,
  localparam int WADDR_W    = PAGE_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic               cpu_ns_i,
  input  logic [WADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic               cpu_gnt_o,
  output logic               cpu_rsp_valid_o,
  output logic               cpu_rsp_err_o,
  output logic [DATA_W-1:0]  cpu_rsp_data_o,
  input  logic               ic_rd_req_i,
  input  logic               ic_rd_ns_i,
  input  logic [WADDR_W-1:0] ic_rd_addr_i,
  output logic               ic_rd_gnt_o,
  input  logic               ic_wr_req_i,
  input  logic               ic_wr_ns_i,
  input  logic [WADDR_W-1:0] ic_wr_addr_i,
  input  logic [DATA_W-1:0]  ic_wr_data_i,
  output logic               ic_wr_gnt_o,
  output logic               ic_rsp_valid_o,
  output logic               ic_rsp_wr_o,
  output logic               ic_rsp_err_o,
  output logic [DATA_W-1:0]  ic_rsp_data_o,
  input  logic               cfg_we_i,
  input  logic [PAGE_W-1:0]  cfg_page_i,
  input  logic               cfg_sec_i,
  input  logic               cfg_ro_i,
  input  logic               cfg_clr_i,
  output logic [1:0]         status_o,
  output logic               irq_o,
  output logic               sram_req_o,
  output logic               sram_we_o,
  output logic [WADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0]  sram_wdata_o,
  input  logic [DATA_W-1:0]  sram_rdata_i
);
  src_e               src;
  pattr_t             attr_lk, cfg_attr;
  logic [WADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0]  acc_wdata;
  logic               acc_we, acc_ns, acc_vld;
  logic               sec_deny, wp_deny;

  ocsram_guard_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_req_i (cpu_req_i),
    .rd_req_i  (ic_rd_req_i),
    .wr_req_i  (ic_wr_req_i),
    .src_o     (src),
    .cpu_gnt_o (cpu_gnt_o),
    .rd_gnt_o  (ic_rd_gnt_o),
    .wr_gnt_o  (ic_wr_gnt_o)
  );

  always_comb begin
    acc_addr  = '0;
    acc_wdata = '0;
    acc_we    = 1'b0;
    acc_ns    = 1'b0;
    unique case (src)
      SRC_CPU: begin
        acc_addr  = cpu_addr_i;
        acc_wdata = cpu_wdata_i;
        acc_we    = cpu_we_i;
        acc_ns    = cpu_ns_i;
      end
      SRC_RD: begin
        acc_addr = ic_rd_addr_i;
        acc_ns   = ic_rd_ns_i;
      end
      SRC_WR: begin
        acc_addr  = ic_wr_addr_i;
        acc_wdata = ic_wr_data_i;
        acc_we    = 1'b1;
        acc_ns    = ic_wr_ns_i;
      end
      default: ;
    endcase
  end

  assign cfg_attr = pattr_t'{ro: cfg_ro_i, sec: cfg_sec_i};

  ocsram_guard_attr #(.PAGE_NUM(PAGE_NUM)) u_attr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_page_i  (cfg_page_i),
    .cfg_attr_i  (cfg_attr),
    .look_page_i (acc_addr[WADDR_W-1 -: PAGE_W]),
    .look_attr_o (attr_lk)
  );

  assign acc_vld  = (src != SRC_NONE);
  assign sec_deny = acc_vld && acc_ns && attr_lk.sec;
  assign wp_deny  = acc_vld && acc_we && attr_lk.ro;

  assign sram_req_o   = acc_vld && !sec_deny && !wp_deny;
  assign sram_we_o    = acc_we;
  assign sram_addr_o  = acc_addr;
  assign sram_wdata_o = acc_wdata;

  ocsram_guard_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .src_i           (src),
    .we_i            (acc_we),
    .sec_deny_i      (sec_deny),
    .wp_deny_i       (wp_deny),
    .clr_i           (cfg_clr_i),
    .sram_rdata_i    (sram_rdata_i),
    .cpu_rsp_valid_o (cpu_rsp_valid_o),
    .cpu_rsp_err_o   (cpu_rsp_err_o),
    .cpu_rsp_data_o  (cpu_rsp_data_o),
    .ic_rsp_valid_o  (ic_rsp_valid_o),
    .ic_rsp_wr_o     (ic_rsp_wr_o),
    .ic_rsp_err_o    (ic_rsp_err_o),
    .ic_rsp_data_o   (ic_rsp_data_o),
    .status_o        (status_o),
    .irq_o           (irq_o)
  );

  AST_SRAM_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_req_o |-> (cpu_gnt_o || ic_rd_gnt_o || ic_wr_gnt_o)); // R2
  AST_DENY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_gnt_o || ic_rd_gnt_o || ic_wr_gnt_o) && !sram_req_o) |=> (cpu_rsp_err_o || ic_rsp_err_o)); // R7
  AST_DENY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_gnt_o || ic_rd_gnt_o || ic_wr_gnt_o) && !sram_req_o) |=> irq_o); // R9
  AST_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_req_o |=> (cpu_rsp_valid_o || ic_rsp_valid_o) && !cpu_rsp_err_o && !ic_rsp_err_o); // R5
endmodule

// File: tb/ocsram_guard_bench.sv
module ocsram_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, cpu_ns = 0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_gnt, cpu_rsp_valid, cpu_rsp_err;
  logic [31:0] cpu_rsp_data;
  logic        rd_req = 0, rd_ns = 0;
  logic [15:0] rd_addr = '0;
  logic        rd_gnt;
  logic        wr_req = 0, wr_ns = 0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_gnt;
  logic        ic_rsp_valid, ic_rsp_wr, ic_rsp_err;
  logic [31:0] ic_rsp_data;
  logic        cfg_we = 0, cfg_sec = 0, cfg_ro = 0, cfg_clr = 0;
  logic [5:0]  cfg_page = '0;
  logic [1:0]  status;
  logic        irq;
  logic        sram_req, sram_we;
  logic [15:0] sram_addr;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocsram_guard u_ocsram_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_ns_i(cpu_ns),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_gnt_o(cpu_gnt),
    .cpu_rsp_valid_o(cpu_rsp_valid), .cpu_rsp_err_o(cpu_rsp_err), .cpu_rsp_data_o(cpu_rsp_data),
    .ic_rd_req_i(rd_req), .ic_rd_ns_i(rd_ns), .ic_rd_addr_i(rd_addr), .ic_rd_gnt_o(rd_gnt),
    .ic_wr_req_i(wr_req), .ic_wr_ns_i(wr_ns), .ic_wr_addr_i(wr_addr), .ic_wr_data_i(wr_data),
    .ic_wr_gnt_o(wr_gnt),
    .ic_rsp_valid_o(ic_rsp_valid), .ic_rsp_wr_o(ic_rsp_wr), .ic_rsp_err_o(ic_rsp_err),
    .ic_rsp_data_o(ic_rsp_data),
    .cfg_we_i(cfg_we), .cfg_page_i(cfg_page), .cfg_sec_i(cfg_sec), .cfg_ro_i(cfg_ro),
    .cfg_clr_i(cfg_clr), .status_o(status), .irq_o(irq),
    .sram_req_o(sram_req), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata)
  );

  // synchronous SRAM model, read data one cycle after the strobe
  bit [31:0] mem [int unsigned];
  always @(posedge clk) begin
    if (sram_req) begin
      if (sram_we) mem[sram_addr] = sram_wdata;
      else sram_rdata <= mem.exists(sram_addr) ? mem[sram_addr] : 32'h0;
    end
  end

  typedef struct packed {
    logic [1:0]  port;   // 0 cpu rd, 1 cpu wr, 2 ic rd, 3 ic wr
    logic        ns;
    logic [17:0] baddr;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VTAB [NV] = '{
    '{2'd1, 1'b1, 18'h00010, 32'hA1A1_0001, 1'b0, 32'h0},
    '{2'd0, 1'b1, 18'h00010, 32'h0,         1'b0, 32'hA1A1_0001},
    '{2'd3, 1'b1, 18'h00024, 32'hB2B2_0002, 1'b0, 32'h0},
    '{2'd2, 1'b1, 18'h00024, 32'h0,         1'b0, 32'hB2B2_0002},
    '{2'd3, 1'b1, 18'h01008, 32'hC3C3_0003, 1'b1, 32'h0},
    '{2'd1, 1'b0, 18'h01008, 32'hC4C4_0004, 1'b0, 32'h0},
    '{2'd2, 1'b1, 18'h01008, 32'h0,         1'b1, 32'h0},
    '{2'd0, 1'b0, 18'h01008, 32'h0,         1'b0, 32'hC4C4_0004},
    '{2'd1, 1'b0, 18'h02000, 32'hD5D5_0005, 1'b1, 32'h0},
    '{2'd2, 1'b1, 18'h02000, 32'h0,         1'b0, 32'h0000_D0D0},
    '{2'd3, 1'b0, 18'h03004, 32'hE6E6_0006, 1'b1, 32'h0},
    '{2'd0, 1'b0, 18'h03004, 32'h0,         1'b0, 32'h0},
    '{2'd3, 1'b1, 18'h3EFFC, 32'hF7F7_0007, 1'b0, 32'h0},
    '{2'd2, 1'b1, 18'h3FFFC, 32'h0,         1'b1, 32'h0},
    '{2'd2, 1'b1, 18'h3EFFC, 32'h0,         1'b0, 32'hF7F7_0007}
  };
  localparam string VTAG [NV] = '{"R5", "R5", "R4", "R4", "R7", "R11", "R7", "R11",
                                  "R8", "R8", "R8", "R8", "R6", "R6", "R6"};

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic drop_reqs();
    cpu_req = 0; rd_req = 0; wr_req = 0; cfg_we = 0; cfg_clr = 0;
  endtask

  task automatic do_acc(input logic [1:0] port, input logic ns, input logic [17:0] baddr,
                        input logic [31:0] wd, input logic exp_err, input logic [31:0] exp_d,
                        input string tag);
    @(negedge clk);
    case (port)
      2'd0, 2'd1: begin
        cpu_req = 1; cpu_we = port[0]; cpu_ns = ns; cpu_addr = baddr[17:2]; cpu_wdata = wd;
      end
      2'd2: begin rd_req = 1; rd_ns = ns; rd_addr = baddr[17:2]; end
      default: begin wr_req = 1; wr_ns = ns; wr_addr = baddr[17:2]; wr_data = wd; end
    endcase
    #1;
    chk(tag, "grant", {29'd0, cpu_gnt, rd_gnt, wr_gnt},
        (port < 2) ? 32'd4 : (port == 2) ? 32'd2 : 32'd1);
    @(negedge clk);
    drop_reqs();
    if (port < 2) begin
      chk(tag, "cpu rsp valid/err", {30'd0, cpu_rsp_valid, cpu_rsp_err}, {30'd0, 1'b1, exp_err});
      chk(tag, "cpu rsp data", cpu_rsp_data, exp_d);
    end else begin
      chk(tag, "ic rsp valid/wr/err", {29'd0, ic_rsp_valid, ic_rsp_wr, ic_rsp_err},
          {29'd0, 1'b1, port[0], exp_err});
      chk(tag, "ic rsp data", ic_rsp_data, exp_d);
    end
  endtask

  task automatic set_page(input logic [5:0] pg, input logic sec, input logic ro);
    @(negedge clk);
    cfg_we = 1; cfg_page = pg; cfg_sec = sec; cfg_ro = ro;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, R9 and R2
    repeat (3) @(negedge clk);
    chk("R9", "status after reset", {30'd0, status}, 32'd0);
    chk("R9", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R2", "no grant or sram strobe in reset", {29'd0, cpu_gnt, rd_gnt, sram_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "no response when idle", {30'd0, cpu_rsp_valid, ic_rsp_valid}, 32'd0);

    // contention from reset: R1, R3, R2
    cpu_req = 1; cpu_we = 0; cpu_ns = 1; cpu_addr = 16'h0040;
    rd_req = 1; rd_ns = 1; rd_addr = 16'h0041;
    wr_req = 1; wr_ns = 1; wr_addr = 16'h0042; wr_data = 32'h1234_5678;
    #1;
    chk("R1", "cpu wins three-way", {29'd0, cpu_gnt, rd_gnt, wr_gnt}, 32'd4);
    @(negedge clk);
    cpu_req = 0;
    #1;
    chk("R3", "read first after reset", {29'd0, cpu_gnt, rd_gnt, wr_gnt}, 32'd2);
    @(negedge clk);
    #1;
    chk("R3", "write after read", {29'd0, cpu_gnt, rd_gnt, wr_gnt}, 32'd1);
    @(negedge clk);
    #1;
    chk("R3", "read after write", {29'd0, cpu_gnt, rd_gnt, wr_gnt}, 32'd2);
    chk("R2", "single sram strobe", {31'd0, sram_req}, 32'd1);
    @(negedge clk);
    drop_reqs();
    @(negedge clk);

    // setup: preload a word, then program attributes (R6)
    do_acc(2'd1, 1'b1, 18'h02000, 32'h0000_D0D0, 1'b0, 32'h0, "R5");
    set_page(6'd1, 1'b1, 1'b0);
    set_page(6'd2, 1'b0, 1'b1);
    set_page(6'd3, 1'b1, 1'b1);
    set_page(6'd63, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++)
      do_acc(VTAB[i].port, VTAB[i].ns, VTAB[i].baddr, VTAB[i].wdata,
             VTAB[i].err, VTAB[i].exp, VTAG[i]);

    // sticky status after mixed denials, R9
    @(negedge clk);
    chk("R9", "both causes sticky", {30'd0, status}, 32'd3);
    chk("R9", "irq raised", {31'd0, irq}, 32'd1);
    cfg_clr = 1;
    @(negedge clk);
    cfg_clr = 0;
    chk("R9", "status cleared", {30'd0, status}, 32'd0);
    chk("R9", "irq cleared", {31'd0, irq}, 32'd0);

    // denial in the clearing cycle still sets its bit, R9
    cfg_clr = 1;
    rd_req = 1; rd_ns = 1; rd_addr = 16'h0400;
    @(negedge clk);
    drop_reqs();
    chk("R7", "denied read error", {31'd0, ic_rsp_err}, 32'd1);
    chk("R9", "set wins over clear", {30'd0, status}, 32'd1);
    cfg_clr = 1;
    @(negedge clk);
    cfg_clr = 0;
    do_acc(2'd1, 1'b0, 18'h02004, 32'h5555_AAAA, 1'b1, 32'h0, "R8");
    chk("R9", "write-protect cause bit", {30'd0, status}, 32'd2);
    do_acc(2'd0, 1'b0, 18'h02004, 32'h0, 1'b0, 32'h0, "R8");

    // attribute write colliding with an access to the same page, R10
    @(negedge clk);
    cfg_we = 1; cfg_page = 6'd5; cfg_sec = 1; cfg_ro = 0;
    rd_req = 1; rd_ns = 1; rd_addr = 16'h1400;
    #1;
    chk("R10", "collision read granted", {31'd0, rd_gnt}, 32'd1);
    @(negedge clk);
    cfg_we = 0;
    chk("R10", "old attribute used", {30'd0, ic_rsp_valid, ic_rsp_err}, 32'd2);
    @(negedge clk);
    drop_reqs();
    chk("R10", "new attribute next cycle", {30'd0, ic_rsp_valid, ic_rsp_err}, 32'd3);

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule